// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

This block is a bus-attached parallel I/O peripheral with three 8-bit ports, named A, B and C. Port C is split into an upper nibble and a lower nibble. A host reaches the block over an 8-bit data bus. It has an active-low chip select, active-low read and write strobes, and a 2-bit register address. Addresses 0, 1 and 2 select ports A, B and C. Address 3 is the write-only command register. The ports fall into two groups. The first group is port A with the upper nibble of C. The second group is port B with the lower nibble of C.

A command byte with its top bit set reconfigures both groups. A command byte with its top bit clear sets or clears one bit of port C. The first group always runs as plain I/O with latched outputs. The second group can run plain, or it can run strobed on port B. In strobed mode the three low bits of port C carry the handshake. Pin direction is given to the pad ring as one output-enable per pin.

Top module: `tri_port_pio`

## Requirements
- R1: After reset every output-enable is 0, every output latch is 0, the second group is in plain mode, and `dout` is 0.
- R2: A write changes nothing unless `cs_n` and `wr_n` are both low in that cycle. `dout` is 0 unless `cs_n` and `rd_n` are both low.
- R3: A write to address 3 with bit 7 = 1 sets the directions and clears all three output latches to 0. The fields are: bit 4 = port A input, bit 3 = upper C input, bit 2 = second group strobed, bit 1 = port B input, bit 0 = lower C input. Bits 6:5 are ignored. An output-enable is 1 exactly on a pin configured as output.
- R4: In plain mode, a write to a port loads its latch, and the latch drives the port's output pins. A read returns the latch bit for an output pin and the input pin for an input pin.
- R5: A write to address 3 with bit 7 = 0 writes bit 0 into port C latch bit number din[3:1] and leaves the other latch bits unchanged.
- R6: A read of address 3 returns 0.
- R7: In strobed input mode, a falling edge on `pc_in[2]` captures `pb_in` and drives `pc_out[1]` (buffer full) to 1. A read of port B returns the captured byte and clears the flag.
- R8: In strobed mode, a set/reset command on bit 2 sets the interrupt enable from its data bit. `pc_out[0]` equals the interrupt enable AND `pc_out[1]`.
- R9: In strobed output mode, `pc_out[1]` is an active-low output-full flag. A port B write drives it low. A later falling edge on `pc_in[2]` (acknowledge) drives it high.
- R10: In strobed mode, a port C read returns the interrupt enable in bit 2, the `pc_out[1]` value in bit 1 and the interrupt in bit 0.
- R11: In strobed mode, `pc_oe[1:0]` = 11 and `pc_oe[2]` = 0. Port B's output-enables follow bit 1 of the command. Bit 3 of lower C follows bit 0 of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, 0 when not read |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output-enables |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output-enables |
| pc_in | input | 8 | Port C input pins (bit 2 is strobe/acknowledge in strobed mode) |
| pc_out | output | 8 | Port C output values (bits 1:0 are handshake in strobed mode) |
| pc_oe | output | 8 | Port C output-enables |

## Verification
The bench builds the block with its default 8-bit width. At that width there are only sixteen direction combinations and sixteen bit set/reset commands. So every direction setting is swept and its output-enable pattern is computed from the command bits. Every set/reset command is swept against a running model of the port C latch. Both strobed directions are then walked through capture, flag clear, acknowledge and interrupt enable, with the status byte predicted bit by bit.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // Direction and mode settings held by the command register.
    typedef struct packed {
        logic a_in;     // port A is input
        logic cu_in;    // upper port C nibble is input
        logic b_mode1;  // second group runs strobed
        logic b_in;     // port B is input
        logic cl_in;    // lower port C nibble is input
    } pio_cfg_t;

    localparam pio_cfg_t PIO_CFG_RST = '{a_in: 1'b1, cu_in: 1'b1, b_mode1: 1'b0,
                                         b_in: 1'b1, cl_in: 1'b1};

    // Handshake state of the strobed group.
    typedef struct packed {
        logic flag;      // input buffer full, or output buffer full
        logic inte;      // interrupt enable
        logic stb_prev;  // strobe/acknowledge pin from the previous cycle
    } pio_hs_t;

endpackage

// File: rtl/pio_cmd_dec.sv
module pio_cmd_dec #(
    parameter int DW   = 8,
    parameter int SELW = 3
) (
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic [1:0]            addr,
    input  logic [DW-1:0]         din,
    output logic                  wr_a,
    output logic                  wr_b,
    output logic                  wr_c,
    output logic                  mode_set,
    output logic                  bsr,
    output logic [SELW-1:0]       bsr_idx,
    output logic                  bsr_val,
    output pio_pkg::pio_cfg_t     cfg_new
);

    logic wsel;
    logic unused_grp_a_mode;

    assign wsel     = !cs_n && !wr_n;
    assign wr_a     = wsel && (addr == 2'd0);
    assign wr_b     = wsel && (addr == 2'd1);
    assign wr_c     = wsel && (addr == 2'd2);
    assign mode_set = wsel && (addr == 2'd3) &&  din[7];
    assign bsr      = wsel && (addr == 2'd3) && !din[7];
    assign bsr_idx  = din[SELW:1];
    assign bsr_val  = din[0];

    assign cfg_new = '{a_in: din[4], cu_in: din[3], b_mode1: din[2],
                       b_in: din[1], cl_in: din[0]};

    // The first group has plain mode only; its mode field is dropped.
    assign unused_grp_a_mode = ^din[6:5];

endmodule

// File: rtl/pio_hshk.sv
module pio_hshk (
    input  logic clk,
    input  logic rst_n,
    input  logic en,        // second group in strobed mode
    input  logic dir_in,    // port B is input
    input  logic clr,       // mode-set command this cycle
    input  logic stb_n,     // strobe (input) or acknowledge (output)
    input  logic rd_b,      // host reads port B
    input  logic wr_b,      // host writes port B
    input  logic inte_we,   // set/reset of the enable bit
    input  logic inte_val,
    output logic cap,       // capture port B input this cycle
    output logic pin1,      // flag pin value
    output logic intr,
    output logic inte
);

    pio_pkg::pio_hs_t hs_q, hs_d;
    logic fall;

    assign fall = hs_q.stb_prev && !stb_n;

    always_comb begin
        hs_d          = hs_q;
        hs_d.stb_prev = stb_n;
        if (clr) begin
            hs_d.flag = 1'b0;
            hs_d.inte = 1'b0;
        end else if (en) begin
            if (inte_we) hs_d.inte = inte_val;
            if (dir_in) begin
                if (fall)      hs_d.flag = 1'b1;
                else if (rd_b) hs_d.flag = 1'b0;
            end else begin
                if (wr_b)      hs_d.flag = 1'b1;
                else if (fall) hs_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '{flag: 1'b0, inte: 1'b0, stb_prev: 1'b1};
        else        hs_q <= hs_d;
    end

    assign cap  = en && dir_in && fall && !clr;
    assign pin1 = dir_in ? hs_q.flag : !hs_q.flag;
    assign intr = hs_q.inte && pin1;
    assign inte = hs_q.inte;

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux #(
    parameter int DW = 8
) (
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] va,
    input  logic [DW-1:0] vb,
    input  logic [DW-1:0] vc,
    output logic [DW-1:0] dout
);

    always_comb begin
        dout = '0;
        if (rd_en) begin
            unique case (addr)
                2'd0:    dout = va;
                2'd1:    dout = vb;
                2'd2:    dout = vc;
                default: dout = '0;
            endcase
        end
    end

endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);

    localparam int NIB  = DW / 2;
    localparam int SELW = $clog2(DW);

    typedef struct packed {
        pio_pkg::pio_cfg_t cfg;
        logic [DW-1:0]     la;
        logic [DW-1:0]     lb;
        logic [DW-1:0]     lc;
    } state_t;

    localparam state_t ST_RST = '{cfg: pio_pkg::PIO_CFG_RST, la: '0, lb: '0, lc: '0};

    state_t st_q, st_d;

    logic              wr_a, wr_b, wr_c, mode_set, bsr, bsr_val;
    logic [SELW-1:0]   bsr_idx;
    pio_pkg::pio_cfg_t cfg_new;
    logic              rd_en, rd_b, cap, pin1, intr, inte;
    logic              gb_m1, gb_in;
    logic [NIB-1:0]    lo_rd, lo_out, lo_oe;
    logic [DW-1:0]     vb, vc;

    pio_cmd_dec #(.DW(DW), .SELW(SELW)) u_dec (
        .cs_n, .wr_n, .addr, .din,
        .wr_a, .wr_b, .wr_c, .mode_set, .bsr, .bsr_idx, .bsr_val, .cfg_new
    );

    assign gb_m1 = st_q.cfg.b_mode1;
    assign gb_in = st_q.cfg.b_in;
    assign rd_en = !cs_n && !rd_n;
    assign rd_b  = rd_en && (addr == 2'd1);

    pio_hshk u_hs (
        .clk, .rst_n,
        .en       (gb_m1),
        .dir_in   (gb_in),
        .clr      (mode_set),
        .stb_n    (pc_in[2]),
        .rd_b     (rd_b),
        .wr_b     (wr_b),
        .inte_we  (bsr && gb_m1 && (bsr_idx == SELW'(2))),
        .inte_val (bsr_val),
        .cap, .pin1, .intr, .inte
    );

    always_comb begin
        st_d = st_q;
        if (mode_set) begin
            st_d.cfg = cfg_new;
            st_d.la  = '0;
            st_d.lb  = '0;
            st_d.lc  = '0;
        end else begin
            if (wr_a) st_d.la = din;
            if (cap)  st_d.lb = pb_in;
            else if (wr_b && !(gb_m1 && gb_in)) st_d.lb = din;
            if (wr_c) st_d.lc = din;
            if (bsr)  st_d.lc[bsr_idx] = bsr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    // Lower port C: plain nibble, or handshake on bits 2:0.
    always_comb begin
        if (gb_m1) begin
            lo_out = {st_q.lc[NIB-1:3], 1'b0, pin1, intr};
            lo_oe  = {{(NIB-3){!st_q.cfg.cl_in}}, 3'b011};
            lo_rd  = {(st_q.cfg.cl_in ? pc_in[NIB-1:3] : st_q.lc[NIB-1:3]), inte, pin1, intr};
        end else begin
            lo_out = st_q.lc[NIB-1:0];
            lo_oe  = {NIB{!st_q.cfg.cl_in}};
            lo_rd  = st_q.cfg.cl_in ? pc_in[NIB-1:0] : st_q.lc[NIB-1:0];
        end
    end

    assign pa_out = st_q.la;
    assign pa_oe  = {DW{!st_q.cfg.a_in}};
    assign pb_out = st_q.lb;
    assign pb_oe  = {DW{!gb_in}};
    assign pc_out = {st_q.lc[DW-1:NIB], lo_out};
    assign pc_oe  = {{(DW-NIB){!st_q.cfg.cu_in}}, lo_oe};

    assign vb = (gb_in && !gb_m1) ? pb_in : st_q.lb;
    assign vc = {(st_q.cfg.cu_in ? pc_in[DW-1:NIB] : st_q.lc[DW-1:NIB]), lo_rd};

    pio_rdmux #(.DW(DW)) u_rd (
        .rd_en, .addr,
        .va   (st_q.cfg.a_in ? pa_in : st_q.la),
        .vb, .vc, .dout
    );

endmodule

// File: rtl/tri_port_pio_chk.sv
module tri_port_pio_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic [1:0]    addr,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pb_out,
    input logic [DW-1:0] pc_in,
    input logic [DW-1:0] pc_out,
    input logic          gb_m1,
    input logic          gb_in
);

    assert_wr_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(pa_out));

    assert_dout_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (dout == '0));

    assert_mode_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == 2'd3 && din[7]) |=>
            (pa_out == '0 && pb_out == '0 && pc_out[DW-1:3] == '0));

    assert_cmd_rd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == 2'd3) |-> (dout == '0));

    assert_ibf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gb_m1 && gb_in && !cs_n && !rd_n && wr_n && addr == 2'd1 && pc_in[2]) |=>
            !pc_out[1]);

    assert_stb_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gb_m1 |-> !pc_out[2]);

endmodule

bind tri_port_pio tri_port_pio_chk #(.DW(DW)) u_chk (
    .clk, .rst_n, .cs_n, .rd_n, .wr_n, .addr, .din, .dout,
    .pa_out, .pb_out, .pc_in, .pc_out, .gb_m1, .gb_in
);

// File: tb/sim_tri_port_pio.sv
`timescale 1ns/1ps
module sim_tri_port_pio;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h04;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    tri_port_pio u0 (
        .clk, .rst_n, .cs_n, .rd_n, .wr_n, .addr, .din, .dout,
        .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe,
        .pc_in, .pc_out, .pc_oe
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = dout;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic pulse_c2();
        @(negedge clk);
        pc_in[2] = 1'b0;
        @(negedge clk);
        pc_in[2] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] lc_model;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
        chk("R1 out", {pa_out, pb_out, pc_out}, 24'h0);
        chk("R1 dout", dout, 0);

        // R6: command register reads as zero
        bus_rd(2'd3, rv);
        chk("R6 cmd read", rv, 0);

        // R3: sweep all direction combinations, mode bits 6:5 ignored
        for (int d = 0; d < 16; d++) begin
            logic [7:0] cmd;
            logic [23:0] exp_oe;
            bus_wr(2'd0, 8'hFF);
            cmd = 8'h80 | 8'((d & 3) << 5) | 8'(((d >> 3) & 1) << 4) |
                  8'(((d >> 2) & 1) << 3) | 8'(((d >> 1) & 1) << 1) | 8'(d & 1);
            bus_wr(2'd3, cmd);
            exp_oe = {(d[3] ? 8'h00 : 8'hFF), (d[1] ? 8'h00 : 8'hFF),
                      (d[2] ? 4'h0 : 4'hF), (d[0] ? 4'h0 : 4'hF)};
            chk("R3 oe sweep", {pa_oe, pb_oe, pc_oe}, exp_oe);
            chk("R3 latch clear", {pa_out, pb_out, pc_out}, 24'h0);
        end

        // R4: all outputs, plain mode
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h5A);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, 8'h96);
        chk("R4 pins", {pa_out, pb_out, pc_out}, 24'h5AC396);
        bus_rd(2'd0, rv); chk("R4 read A", rv, 8'h5A);
        bus_rd(2'd1, rv); chk("R4 read B", rv, 8'hC3);
        bus_rd(2'd2, rv); chk("R4 read C", rv, 8'h96);

        // R2: no effect without chip select
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        #1 chk("R2 dout without cs", dout, 0);
        @(negedge clk);
        rd_n = 1'b1;
        chk("R2 write without cs", pa_out, 8'h5A);

        // R5: sweep every set/reset command
        lc_model = 8'h96;
        for (int k = 0; k < 16; k++) begin
            bus_wr(2'd3, 8'(k));
            lc_model[k >> 1] = k[0];
            chk("R5 bit set/reset", pc_out, lc_model);
        end

        // R4: plain inputs
        bus_wr(2'd3, 8'h9B);
        pa_in = 8'hE1; pb_in = 8'h4D; pc_in = 8'h7E;
        bus_rd(2'd0, rv); chk("R4 input A", rv, 8'hE1);
        bus_rd(2'd1, rv); chk("R4 input B", rv, 8'h4D);
        bus_rd(2'd2, rv); chk("R4 input C", rv, 8'h7E);

        // R4: mixed port C, upper in / lower out
        bus_wr(2'd3, 8'h88);
        bus_wr(2'd2, 8'hA5);
        pc_in = 8'h3C;
        bus_rd(2'd2, rv); chk("R4 mixed C read", rv, 8'h35);
        chk("R4 mixed C oe", pc_oe, 8'h0F);

        // R7, R8, R10, R11: strobed input
        pc_in = 8'h04;
        bus_wr(2'd3, 8'h86);
        chk("R11 oe strobed in", {pb_oe, pc_oe}, 16'h00FB);
        chk("R7 flag idle", pc_out[1], 0);
        pb_in = 8'h77;
        pulse_c2();
        pb_in = 8'h11;
        chk("R7 flag set", pc_out[1], 1);
        chk("R8 intr off when disabled", pc_out[0], 0);
        bus_rd(2'd1, rv); chk("R7 captured byte", rv, 8'h77);
        chk("R7 flag cleared by read", pc_out[1], 0);
        bus_wr(2'd3, 8'h05);
        pb_in = 8'h22;
        pulse_c2();
        chk("R8 intr raised", pc_out[1:0], 2'b11);
        bus_rd(2'd2, rv); chk("R10 status read", rv, 8'h07);
        bus_rd(2'd1, rv); chk("R7 second capture", rv, 8'h22);
        chk("R8 intr drops after read", pc_out[1:0], 2'b00);

        // R9, R11: strobed output
        bus_wr(2'd3, 8'h84);
        chk("R11 oe strobed out", {pb_oe, pc_oe}, 16'hFFFB);
        chk("R9 idle not full", pc_out, 8'h02);
        bus_wr(2'd1, 8'h99);
        chk("R9 pin data", pb_out, 8'h99);
        chk("R9 full low", pc_out[1], 0);
        pulse_c2();
        chk("R9 ack clears", pc_out[1], 1);
        bus_wr(2'd3, 8'h05);
        chk("R8 intr out mode", pc_out, 8'h03);
        bus_wr(2'd1, 8'h3E);
        chk("R9 intr drops on write", pc_out[1:0], 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule